// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block receives bytes from an idle-high asynchronous serial line. It uses a baud tick that pulses sixteen times per bit period. When the line falls, the block checks the start bit at its midpoint. It then samples eight data bits, least significant first, an optional parity bit and one stop bit. Each of these bits is sampled once at its midpoint. At the end of the frame the byte goes into a holding register, and a set of status flags records how the frame ended.

There are four status flags: receive-full, overrun, parity error and framing error. A read strobe, which stands for the host reading the holding register, clears receive-full. A separate clear strobe clears the three error flags. Two level interrupt requests follow the flags: one for a received byte and one for any error. Both are gated by a single receive-interrupt enable. A host keeps reception continuous by reading each byte before the next frame finishes.

Top module: `serial_rx_unit`

## Requirements
- R1: A frame is a start bit (0), eight data bits sent bit 0 first, an optional parity bit and one stop bit (1). The line idles at 1. The byte shown on `rx_data` has bit 0 equal to the first data bit received.
- R2: If the line has gone high again by the eighth baud tick after a falling edge was seen, the edge is treated as a glitch. The receiver returns to idle, and no flag or data changes.
- R3: A frame with no error, completing while receive-full is 0 and no error flag is set, loads `rx_data` and sets `rx_full`. `rx_data` changes only on the cycle after a frame completes.
- R4: A pulse on `host_read` clears `rx_full`. A read in the same cycle as a frame completion is taken first, so that frame does not count as an overrun.
- R5: If a frame completes while `rx_full` is 1, `rx_overrun` is set and `rx_data` keeps the earlier byte.
- R6: When `parity_on` is 1, a parity bit follows the data. With `parity_odd` 0 (even parity), the XOR of the data bits and the parity bit must be 0. With `parity_odd` 1 (odd parity), it must be 1. When `parity_on` is 0, the stop bit follows bit 7 directly.
- R7: A parity mismatch sets `rx_parity_err` and still loads the byte into `rx_data`. `rx_full` is not set.
- R8: A stop bit sampled as 0 sets `rx_frame_err` and still loads the byte into `rx_data`. `rx_full` is not set.
- R9: The three error flags stay set until `err_clear` pulses. While any error flag is set, an error-free frame loads `rx_data` but does not set `rx_full`.
- R10: `irq_rx` is high when `irq_enable` and `rx_full` are both 1. `irq_err` is high when `irq_enable` is 1 and any error flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| baud_tick | input | 1 | One-cycle pulse, sixteen per bit period |
| serial_in | input | 1 | Asynchronous serial line, idles high |
| parity_on | input | 1 | 1 = the frame carries a parity bit |
| parity_odd | input | 1 | 1 = odd parity, 0 = even parity |
| host_read | input | 1 | Holding-register read strobe; clears receive-full |
| err_clear | input | 1 | Strobe that clears the error flags |
| irq_enable | input | 1 | Receive-interrupt enable |
| rx_data | output | 8 | Holding register |
| rx_full | output | 1 | Receive-full flag |
| rx_overrun | output | 1 | Overrun flag |
| rx_parity_err | output | 1 | Parity-error flag |
| rx_frame_err | output | 1 | Framing-error flag |
| irq_rx | output | 1 | Receive-complete interrupt request |
| irq_err | output | 1 | Error interrupt request |

## Verification
The assertions assume that `host_read` and `err_clear` are single-cycle strobes and that `baud_tick` is a clean periodic pulse. They also assume that the configuration inputs do not change in the middle of a frame. The bench produces its tick from a fixed divider. It drives every line level and strobe on the falling clock edge, and it changes the parity settings only while the line is idle between frames. Overrun frames and glitch pulses are whole, well-formed line patterns; they are never a half-bit race against a strobe.

// File: rtl/serial_rx_pkg.sv
// Shared types for the serial receiver.
// Assumes: used only by the serial_rx_unit hierarchy.
package serial_rx_pkg;

    // Frame sequencer states
    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP
    } rx_state_e;

endpackage

// File: rtl/srx_line_sync.sv
// Synchronises the asynchronous serial line into the clock domain.
// Assumes: SYNC_STAGES >= 1. The chain resets to the idle (mark) level.
module srx_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_async,
    output logic line_sync
);
    logic [SYNC_STAGES-1:0] chain;

    generate
        for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
            // Purpose: one flop of the synchroniser chain
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain[s] <= 1'b1;
                end else if (s == 0) begin
                    chain[s] <= line_async;
                end else begin
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign line_sync = chain[SYNC_STAGES-1];
endmodule

// File: rtl/srx_frame_fsm.sv
// Frame sequencer: finds the start bit, samples each bit once at its
// midpoint on the oversampling tick, and checks parity and stop.
// Assumes: tick pulses OS_RATE times per bit, line is synchronised,
// and the parity settings are held steady for the whole frame.
module srx_frame_fsm
    import serial_rx_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int OS_RATE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              line,
    input  logic              par_en,
    input  logic              par_odd,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic              par_bad,
    output logic              stop_bad
);
    localparam int CW = $clog2(OS_RATE);
    localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CW-1:0] HALF_M1 = CW'(OS_RATE/2 - 1);
    localparam logic [CW-1:0] FULL_M1 = CW'(OS_RATE - 1);
    localparam logic [IW-1:0] LAST_BIT = IW'(DATA_W - 1);

    rx_state_e         state;
    logic [CW-1:0]     os_cnt;
    logic [IW-1:0]     bit_idx;
    logic [DATA_W-1:0] shreg;
    logic              par_acc;
    logic              par_bad_q;
    logic              at_mid;

    // Purpose: mark the tick on which the current bit is sampled
    always_comb begin
        if (state == RX_START) at_mid = tick && (os_cnt == HALF_M1);
        else                   at_mid = tick && (os_cnt == FULL_M1);
    end

    // Purpose: state sequencing, bit counting and data shifting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= RX_IDLE;
            os_cnt    <= '0;
            bit_idx   <= '0;
            shreg     <= '0;
            par_acc   <= 1'b0;
            par_bad_q <= 1'b0;
            done      <= 1'b0;
            data      <= '0;
            par_bad   <= 1'b0;
            stop_bad  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (tick && !at_mid && state != RX_IDLE) os_cnt <= os_cnt + 1'b1;
            unique case (state)
                RX_IDLE: if (tick && !line) begin
                    state  <= RX_START;
                    os_cnt <= '0;
                end
                RX_START: if (at_mid) begin
                    os_cnt    <= '0;
                    bit_idx   <= '0;
                    par_acc   <= 1'b0;
                    par_bad_q <= 1'b0;
                    state     <= line ? RX_IDLE : RX_DATA;
                end
                RX_DATA: if (at_mid) begin
                    os_cnt  <= '0;
                    shreg   <= {line, shreg[DATA_W-1:1]};
                    par_acc <= par_acc ^ line;
                    bit_idx <= bit_idx + 1'b1;
                    if (bit_idx == LAST_BIT) state <= par_en ? RX_PARITY : RX_STOP;
                end
                RX_PARITY: if (at_mid) begin
                    os_cnt    <= '0;
                    par_bad_q <= ((par_acc ^ line) != par_odd);
                    state     <= RX_STOP;
                end
                RX_STOP: if (at_mid) begin
                    os_cnt   <= '0;
                    done     <= 1'b1;
                    data     <= shreg;
                    par_bad  <= par_bad_q;
                    stop_bad <= !line;
                    state    <= RX_IDLE;
                end
                default: state <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/srx_status_regs.sv
// Holding register, status flags and interrupt requests.
// Assumes: done is a one-cycle pulse; read and clear are one-cycle strobes.
module srx_status_regs #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [DATA_W-1:0] frame_data,
    input  logic              par_bad,
    input  logic              stop_bad,
    input  logic              rd_strobe,
    input  logic              clr_strobe,
    input  logic              irq_en,
    output logic [DATA_W-1:0] hold_data,
    output logic              full,
    output logic              ovr,
    output logic              perr,
    output logic              ferr,
    output logic              irq_rx,
    output logic              irq_err
);
    logic full_eff;
    logic err_eff;

    // Purpose: flag values after this cycle's read and clear strobes are applied
    always_comb begin
        full_eff = full && !rd_strobe;
        err_eff  = (ovr || perr || ferr) && !clr_strobe;
    end

    // Purpose: update the holding register and the status flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_data <= '0;
            full      <= 1'b0;
            ovr       <= 1'b0;
            perr      <= 1'b0;
            ferr      <= 1'b0;
        end else begin
            if (rd_strobe) full <= 1'b0;
            if (clr_strobe) begin
                ovr  <= 1'b0;
                perr <= 1'b0;
                ferr <= 1'b0;
            end
            if (done) begin
                if (full_eff) begin
                    ovr <= 1'b1;
                end else begin
                    hold_data <= frame_data;
                    if (par_bad)  perr <= 1'b1;
                    if (stop_bad) ferr <= 1'b1;
                    if (!par_bad && !stop_bad && !err_eff) full <= 1'b1;
                end
            end
        end
    end

    // Purpose: level interrupt requests gated by the enable
    always_comb begin
        irq_rx  = irq_en && full;
        irq_err = irq_en && (ovr || perr || ferr);
    end
endmodule

// File: rtl/serial_rx_unit.sv
// Top of the asynchronous serial receiver: synchroniser, frame
// sequencer and status registers.
// Assumes: baud_tick pulses sixteen times per bit period.
module serial_rx_unit #(
    parameter int DATA_W      = 8,
    parameter int OS_RATE     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              serial_in,
    input  logic              parity_on,
    input  logic              parity_odd,
    input  logic              host_read,
    input  logic              err_clear,
    input  logic              irq_enable,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              rx_overrun,
    output logic              rx_parity_err,
    output logic              rx_frame_err,
    output logic              irq_rx,
    output logic              irq_err
);
    logic              line_s;
    logic              frame_done;
    logic [DATA_W-1:0] frame_byte;
    logic              frame_par_bad;
    logic              frame_stop_bad;

    srx_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_async (serial_in),
        .line_sync  (line_s)
    );

    srx_frame_fsm #(.DATA_W(DATA_W), .OS_RATE(OS_RATE)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (baud_tick),
        .line     (line_s),
        .par_en   (parity_on),
        .par_odd  (parity_odd),
        .done     (frame_done),
        .data     (frame_byte),
        .par_bad  (frame_par_bad),
        .stop_bad (frame_stop_bad)
    );

    srx_status_regs #(.DATA_W(DATA_W)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .done       (frame_done),
        .frame_data (frame_byte),
        .par_bad    (frame_par_bad),
        .stop_bad   (frame_stop_bad),
        .rd_strobe  (host_read),
        .clr_strobe (err_clear),
        .irq_en     (irq_enable),
        .hold_data  (rx_data),
        .full       (rx_full),
        .ovr        (rx_overrun),
        .perr       (rx_parity_err),
        .ferr       (rx_frame_err),
        .irq_rx     (irq_rx),
        .irq_err    (irq_err)
    );
endmodule

// File: rtl/srx_checker.sv
// Checker for serial_rx_unit: temporal properties on the flags and the
// holding register. Assumes single-cycle read and clear strobes.
module srx_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic              rd_strobe,
    input logic              clr_strobe,
    input logic              irq_en,
    input logic [DATA_W-1:0] data_out,
    input logic              full,
    input logic              ovr,
    input logic              perr,
    input logic              ferr,
    input logic              irq_rx,
    input logic              irq_err
);
    // R9
    full_rise_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full) |-> !(ovr || perr || ferr));

    // R4
    read_clears_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !done) |=> !full);

    // R5
    overrun_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> $stable(data_out));

    // R9
    perr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (perr && !clr_strobe) |=> perr);

    // R9
    ferr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ferr && !clr_strobe) |=> ferr);

    // R10
    irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_rx || irq_err) |-> irq_en);

    // R3
    data_only_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data_out) |-> $past(done));
endmodule

bind serial_rx_unit srx_checker #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .done       (frame_done),
    .rd_strobe  (host_read),
    .clr_strobe (err_clear),
    .irq_en     (irq_enable),
    .data_out   (rx_data),
    .full       (rx_full),
    .ovr        (rx_overrun),
    .perr       (rx_parity_err),
    .ferr       (rx_frame_err),
    .irq_rx     (irq_rx),
    .irq_err    (irq_err)
);

// File: tb/serial_rx_unit_test.sv
module serial_rx_unit_test;
    localparam int TICK_DIV = 4;
    localparam int OS = 16;
    localparam int BIT_CLKS = OS * TICK_DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick;
    logic       serial_in = 1'b1;
    logic       parity_on = 1'b0;
    logic       parity_odd = 1'b0;
    logic       host_read = 1'b0;
    logic       err_clear = 1'b0;
    logic       irq_enable = 1'b1;
    logic [7:0] rx_data;
    logic       rx_full, rx_overrun, rx_parity_err, rx_frame_err, irq_rx, irq_err;
    int         div_cnt = 0;
    int         checks = 0;
    int         errors = 0;
    bit         done_flag = 1'b0;

    always #2 clk = ~clk;

    // Tick generator, updated away from the active edge
    always @(negedge clk) div_cnt <= (div_cnt == TICK_DIV-1) ? 0 : div_cnt + 1;
    assign baud_tick = (div_cnt == 0);

    serial_rx_unit uut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .serial_in(serial_in),
        .parity_on(parity_on), .parity_odd(parity_odd), .host_read(host_read),
        .err_clear(err_clear), .irq_enable(irq_enable), .rx_data(rx_data),
        .rx_full(rx_full), .rx_overrun(rx_overrun), .rx_parity_err(rx_parity_err),
        .rx_frame_err(rx_frame_err), .irq_rx(irq_rx), .irq_err(irq_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic line_bit(input logic v);
        serial_in = v;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    // Sends one frame; bad_par flips the parity bit, stop_v is the stop level
    task automatic send_frame(input logic [7:0] d, input bit bad_par, input logic stop_v);
        logic p;
        p = parity_odd ? ~^d : ^d;
        if (bad_par) p = ~p;
        line_bit(1'b0);
        for (int i = 0; i < 8; i++) line_bit(d[i]);
        if (parity_on) line_bit(p);
        line_bit(stop_v);
        serial_in = 1'b1;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    task automatic pulse_read();
        host_read = 1'b1; @(negedge clk); host_read = 1'b0; @(negedge clk);
    endtask

    task automatic pulse_clear();
        err_clear = 1'b1; @(negedge clk); err_clear = 1'b0; @(negedge clk);
    endtask

    task automatic t_reset();
        check("R3 reset data", rx_data, 8'h00);
        check("R3 reset full", rx_full, 0);
        check("R9 reset errs", {rx_overrun, rx_parity_err, rx_frame_err}, 0);
        check("R10 reset irqs", {irq_rx, irq_err}, 0);
    endtask

    task automatic t_good_byte();
        parity_on = 1'b0;
        send_frame(8'h1E, 0, 1'b1);
        check("R1 bit order data", rx_data, 8'h1E);
        check("R3 full set", rx_full, 1);
        check("R10 irq_rx on", irq_rx, 1);
        check("R10 irq_err off", irq_err, 0);
        irq_enable = 1'b0; @(negedge clk);
        check("R10 irq_rx gated", irq_rx, 0);
        irq_enable = 1'b1; @(negedge clk);
        pulse_read();
        check("R4 read clears full", rx_full, 0);
        check("R4 irq_rx drops", irq_rx, 0);
    endtask

    task automatic t_parity_ok();
        parity_on = 1'b1; parity_odd = 1'b0;
        send_frame(8'h3C, 0, 1'b1);
        check("R6 even data", rx_data, 8'h3C);
        check("R6 even no perr", {rx_full, rx_parity_err}, 2'b10);
        pulse_read();
        parity_odd = 1'b1;
        send_frame(8'h01, 0, 1'b1);
        check("R6 odd data", rx_data, 8'h01);
        check("R6 odd no perr", {rx_full, rx_parity_err}, 2'b10);
        pulse_read();
    endtask

    task automatic t_parity_bad();
        parity_on = 1'b1; parity_odd = 1'b0;
        send_frame(8'h5A, 1, 1'b1);
        check("R7 perr set", rx_parity_err, 1);
        check("R7 byte loaded", rx_data, 8'h5A);
        check("R7 full clear", rx_full, 0);
        check("R10 irq_err on", irq_err, 1);
        parity_on = 1'b0;
        send_frame(8'h11, 0, 1'b1);
        check("R9 loaded while err", rx_data, 8'h11);
        check("R9 no full while err", rx_full, 0);
        check("R9 perr sticky", rx_parity_err, 1);
        pulse_clear();
        check("R9 clear perr", rx_parity_err, 0);
        check("R10 irq_err off", irq_err, 0);
    endtask

    task automatic t_frame_err();
        parity_on = 1'b0;
        send_frame(8'h77, 0, 1'b0);
        check("R8 ferr set", rx_frame_err, 1);
        check("R8 byte loaded", rx_data, 8'h77);
        check("R8 full clear", rx_full, 0);
        pulse_clear();
        check("R9 clear ferr", rx_frame_err, 0);
    endtask

    task automatic t_overrun();
        parity_on = 1'b0;
        send_frame(8'h12, 0, 1'b1);
        send_frame(8'h34, 0, 1'b1);
        check("R5 ovr set", rx_overrun, 1);
        check("R5 old byte kept", rx_data, 8'h12);
        check("R5 full still", rx_full, 1);
        pulse_read();
        pulse_clear();
        check("R9 clear ovr", rx_overrun, 0);
    endtask

    task automatic t_glitch();
        serial_in = 1'b0;
        repeat (3 * TICK_DIV) @(negedge clk);
        serial_in = 1'b1;
        repeat (12 * BIT_CLKS) @(negedge clk);
        check("R2 glitch data", rx_data, 8'h12);
        check("R2 glitch flags", {rx_full, rx_overrun, rx_parity_err, rx_frame_err}, 0);
        send_frame(8'h9C, 0, 1'b1);
        check("R2 recovers", rx_data, 8'h9C);
        check("R2 recovers full", rx_full, 1);
        pulse_read();
    endtask

    initial begin
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_good_byte();
        t_parity_ok();
        t_parity_bad();
        t_frame_err();
        t_overrun();
        t_glitch();
        done_flag = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule